// File: doc/BRIEF.md
# Channel Fault Qualifier and Status Latch

This block sits between sixteen low-side output channels and the serial status word. Each channel carries a drain comparator flag. Read against the channel's command state and its enable bits, that flag means either a short (output on, drain above threshold) or an open load (output off, pull-down current enabled, drain pulled below threshold). A suspected fault has to hold for a programmable number of timebase ticks before it counts. The hold count starts again whenever the comparator drops and whenever chip select rises. This masks the switching transients that follow each new command.

A qualified fault sets that channel's status bit. A thermal flag sets the bit directly, with no filtering. The bits stay set until the next chip-select rising edge, which is the moment the new command word takes effect. A qualified short on a channel without thermal-only protection also raises a shutdown request for that channel, and that request is held until the same clearing edge. A summary flag is raised when any status bit is set or when the supply over-voltage flag is active.

Top module: `fault_filter_latch`

## Requirements
- R1: After reset every status bit and every shutdown request is 0, and `any_fault` follows `ov_flt` alone.
- R2: A channel with `cmd_on`=1, `drain_hi`=1 and `thermal_only`=0 held through FILT_TICKS tick cycles (default 300) sets its `fault_q` bit and its `short_off` bit after the last of those ticks. One tick fewer sets neither.
- R3: With `thermal_only`=1, a channel that is on with its drain high sets neither its fault bit nor its shutdown request.
- R4: A channel with `cmd_on`=0, `drain_hi`=0 and `ol_en`=1 held through FILT_TICKS ticks sets its fault bit and never its shutdown request.
- R5: No open-load fault is reported when `ol_en`=0, or when the channel is commanded on with its drain low.
- R6: If a channel's fault condition drops for one cycle, that channel's count restarts, and FILT_TICKS further ticks are needed to set the bit.
- R7: A chip-select rising edge (`cs_n` going 0 to 1) restarts every channel's count.
- R8: A set fault bit stays set after its condition clears and while `cs_n` is low. It is cleared by the clock edge that sees `cs_n` rise, and so are the shutdown requests.
- R9: A `therm_flt` bit sets the matching fault bit at the next clock edge, with no filtering. This also holds in the cycle that sees `cs_n` rise, where the new thermal bit is kept and the other bits are cleared.
- R10: `any_fault` is 1 exactly when some `fault_q` bit is 1 or `ov_flt` is 1.
- R11: The count advances only in cycles where `tick_us`=1. Sparse ticks stretch the window in clock cycles but leave the number of ticks needed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, synchronous to clk; its rising edge clears and restarts |
| tick_us | input | 1 | One-cycle timebase pulse (1 µs) |
| cmd_on | input | NCH | Commanded state per channel (1 = on) |
| drain_hi | input | NCH | Drain comparator per channel (1 = above threshold) |
| ol_en | input | NCH | Open-load pull-down current enable per channel |
| thermal_only | input | NCH | 1 = channel relies on thermal shutdown only, no short qualification |
| therm_flt | input | NCH | Thermal fault flag per channel |
| ov_flt | input | 1 | Supply over-voltage flag |
| fault_q | output | NCH | Latched fault bits for readout |
| any_fault | output | 1 | OR of latched bits and over-voltage |
| short_off | output | NCH | Per-channel shutdown request after a qualified short |

## Verification
The assertions take the comparator, command and enable inputs to be synchronous to `clk`. They also take `cs_n` to be already synchronised, so that one rising edge is seen in exactly one cycle. The stimulus changes every input only on the falling clock edge. It changes command and enable bits only while chip select is low, and the next rise of chip select then restarts the counts, as happens when a real command is written. Ticks are single-cycle pulses and are never asserted during the chip-select sequence.

// File: rtl/fflt_pkg.sv
package fflt_pkg;

  typedef struct packed {
    logic shrt;
    logic open;
  } cond_t;

  // Classify one channel's comparator reading against its command and enables.
  function automatic cond_t classify(input logic on, input logic hi,
                                     input logic ol, input logic th_only);
    cond_t c;
    c.shrt = on & hi & ~th_only;
    c.open = ~on & ~hi & ol;
    return c;
  endfunction

endpackage

// File: rtl/fflt_csedge.sv
module fflt_csedge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_rise
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_rise = cs_n & ~cs_q;

  // R7: a rising edge is a single-cycle event
  assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !cs_rise);

endmodule

// File: rtl/fflt_chan.sv
module fflt_chan #(
  parameter int FILT_TICKS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_rise,
  input  logic tick,
  input  logic cmd_on,
  input  logic drain_hi,
  input  logic ol_en,
  input  logic thermal_only,
  input  logic therm,
  output logic fault_q,
  output logic shut_q
);
  import fflt_pkg::*;

  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          fault_d, shut_d;
  logic          hold, qual;
  cond_t         c;

  always_comb begin
    c      = classify(cmd_on, drain_hi, ol_en, thermal_only);
    hold   = c.shrt | c.open;
    qual   = tick & hold & ~cs_rise & (cnt_q == LAST);
    cnt_en = cs_rise | ~hold | (tick & (cnt_q != FULL));
    if (cs_rise || !hold) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
    fault_d = (fault_q & ~cs_rise) | qual | therm;
    shut_d  = (shut_q & ~cs_rise) | (qual & c.shrt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
      shut_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      fault_q <= fault_d;
      shut_q  <= shut_d;
    end
  end

  // R11: the count never passes the window length
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R2: a shutdown request is always accompanied by a latched fault
  assert_shut_has_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |-> fault_q);

  // R5: a filtered set needs an on+high short or an off+low enabled open load
  assert_set_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_q) && !$past(therm)) |->
      ($past(cmd_on) ? ($past(drain_hi) && !$past(thermal_only))
                     : (!$past(drain_hi) && $past(ol_en))));

  // R8: a chip-select rise with no thermal flag leaves the bit clear
  assert_clear_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !therm) |=> (!fault_q && !shut_q));

endmodule

// File: rtl/fault_filter_latch.sv
module fault_filter_latch #(
  parameter int NCH        = 16,
  parameter int FILT_TICKS = 300
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           tick_us,
  input  logic [NCH-1:0] cmd_on,
  input  logic [NCH-1:0] drain_hi,
  input  logic [NCH-1:0] ol_en,
  input  logic [NCH-1:0] thermal_only,
  input  logic [NCH-1:0] therm_flt,
  input  logic           ov_flt,
  output logic [NCH-1:0] fault_q,
  output logic           any_fault,
  output logic [NCH-1:0] short_off
);
  logic cs_rise;

  fflt_csedge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cs_rise (cs_rise)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    fflt_chan #(.FILT_TICKS(FILT_TICKS)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_rise      (cs_rise),
      .tick         (tick_us),
      .cmd_on       (cmd_on[g]),
      .drain_hi     (drain_hi[g]),
      .ol_en        (ol_en[g]),
      .thermal_only (thermal_only[g]),
      .therm        (therm_flt[g]),
      .fault_q      (fault_q[g]),
      .shut_q       (short_off[g])
    );
  end

  assign any_fault = (|fault_q) | ov_flt;

endmodule

// File: tb/tb_fault_filter_latch.sv
`timescale 1ns/1ps
module tb_fault_filter_latch;
  localparam int NCH  = 16;
  localparam int FILT = 300;

  logic clk, rst_n, cs_n, tick_us, ov_flt;
  logic [NCH-1:0] cmd_on, drain_hi, ol_en, thermal_only, therm_flt;
  logic [NCH-1:0] fault_q, short_off;
  logic any_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  fault_filter_latch #(.NCH(NCH), .FILT_TICKS(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .tick_us(tick_us),
    .cmd_on(cmd_on), .drain_hi(drain_hi), .ol_en(ol_en),
    .thermal_only(thermal_only), .therm_flt(therm_flt), .ov_flt(ov_flt),
    .fault_q(fault_q), .any_fault(any_fault), .short_off(short_off)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: cmd, drain, thermal_only, ol_en, ticks, expected fault, expected shutdown
  localparam logic [111:0] VEC [0:5] = '{
    {16'h000F, 16'h0003, 16'h0002, 16'h0000, 16'd300, 16'h0001, 16'h0001},
    {16'h0000, 16'h00F0, 16'h0000, 16'h0300, 16'd300, 16'h0300, 16'h0000},
    {16'h000F, 16'h0003, 16'h0002, 16'h0000, 16'd299, 16'h0000, 16'h0000},
    {16'hFF00, 16'hFFFF, 16'h0F00, 16'h00FF, 16'd300, 16'hF000, 16'hF000},
    {16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'd300, 16'hFFFF, 16'h0000},
    {16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'd300, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cs_pulse();
    cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    tick_us = 1'b1;
    repeat (n) @(negedge clk);
    tick_us = 1'b0;
  endtask

  task automatic set_in(input logic [15:0] c, input logic [15:0] d,
                        input logic [15:0] t, input logic [15:0] o);
    cmd_on = c; drain_hi = d; thermal_only = t; ol_en = o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; tick_us = 1'b0; ov_flt = 1'b0;
    cmd_on = '0; drain_hi = '0; ol_en = '0; thermal_only = '0; therm_flt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fault", 32'(fault_q), 32'h0);
    chk("R1 short", 32'(short_off), 32'h0);
    chk("R1 any", 32'(any_fault), 32'h0);
    ov_flt = 1'b1; #1;
    chk("R10 any with ov", 32'(any_fault), 32'h1);
    ov_flt = 1'b0;

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic [111:0] v;
      v = VEC[i];
      set_in(v[111:96], v[95:80], v[79:64], v[63:48]);
      cs_pulse();
      tick_n(int'(v[47:32]));
      chk($sformatf("R2/R3/R4/R5 vec%0d fault", i), 32'(fault_q), 32'(v[31:16]));
      chk($sformatf("R2/R3/R4/R5 vec%0d short", i), 32'(short_off), 32'(v[15:0]));
      chk($sformatf("R10 vec%0d any", i), 32'(any_fault), 32'(|v[31:16]));
    end

    // R6 comparator drop restarts the count
    set_in(16'h0001, 16'h0001, 16'h0000, 16'h0000);
    cs_pulse();
    tick_n(299);
    drain_hi = 16'h0000;
    @(negedge clk);
    drain_hi = 16'h0001;
    tick_n(299);
    chk("R6 after drop", 32'(fault_q), 32'h0);
    tick_n(1);
    chk("R6 full window", 32'(fault_q), 32'h1);
    chk("R6 short", 32'(short_off), 32'h1);

    // R8 latch holds after condition clears and while cs_n is low
    drain_hi = 16'h0000;
    repeat (10) @(negedge clk);
    chk("R8 held", 32'(fault_q), 32'h1);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 held cs low", 32'(fault_q), 32'h1);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R8 cleared fault", 32'(fault_q), 32'h0);
    chk("R8 cleared short", 32'(short_off), 32'h0);

    // R7 chip-select rise restarts the count
    drain_hi = 16'h0001;
    cs_pulse();
    tick_n(299);
    cs_pulse();
    tick_n(299);
    chk("R7 restarted", 32'(fault_q), 32'h0);
    tick_n(1);
    chk("R7 full window", 32'(fault_q), 32'h1);

    // R11 sparse ticks
    cs_pulse();
    for (int k = 0; k < 299; k++) begin
      tick_us = 1'b1; @(negedge clk);
      tick_us = 1'b0; @(negedge clk); @(negedge clk);
    end
    chk("R11 299 sparse", 32'(fault_q), 32'h0);
    tick_n(1);
    chk("R11 300 sparse", 32'(fault_q), 32'h1);

    // R9 thermal latches unfiltered, and survives the clearing edge
    set_in(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    cs_pulse();
    therm_flt = 16'h0020;
    @(negedge clk);
    therm_flt = 16'h0000;
    chk("R9 thermal", 32'(fault_q), 32'h0020);
    chk("R9 no short", 32'(short_off), 32'h0);
    cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    therm_flt = 16'h0040;
    @(negedge clk);
    therm_flt = 16'h0000;
    chk("R9 coincident", 32'(fault_q), 32'h0040);

    // R10 summary with nothing latched
    cs_pulse();
    chk("R10 none", 32'(any_fault), 32'h0);
    ov_flt = 1'b1; #1;
    chk("R10 ov only", 32'(any_fault), 32'h1);
    ov_flt = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule